// File: doc/BRIEF.md
# Host-Queue Doorbell Command Engine

This engine sits on the device side of a paired command ring and completion ring, both kept in host memory. The host puts 64-byte commands into the submission ring. It then writes the new submission tail index to a doorbell port. The engine fetches each pending command as eight 64-bit bus-master read beats and hands the assembled command to an executor over a valid/ready handshake. It waits for the executor's status, then writes a 16-byte completion entry into the completion ring as two 64-bit write beats. The interrupt request follows only after the second beat has been accepted.

The host consumes completions and returns the slots by writing the completion head doorbell. Both rings have `DEPTH` slots. Every index wraps to zero at `DEPTH`, and a ring is empty when its head equals its tail. A completion phase bit starts at 1 and flips each time the completion tail wraps. The ring base addresses are parameters. The engine handles one command at a time, in a fixed order: fetch, execute, post, interrupt.

Top module: `hq_doorbell_engine`

## Requirements
- R1: After reset, `irq`, `mem_req`, `cmd_valid` and `db_err` are all low, and no memory request is made until a submission doorbell makes the submission ring non-empty.
- R2: A doorbell write with `db_sel`=0 and a value below `DEPTH` sets the submission tail. While the submission head differs from the tail, the engine fetches the command at the head slot as 8 read beats. Beat b goes to address `SQ_BASE + slot*64 + b*8`. The submission head advances after the eighth beat is accepted.
- R3: `cmd_data` carries the fetched command, with read beat k in bits [64k+63:64k]. `cmd_valid` and `cmd_data` stay unchanged until `cmd_ready` is seen.
- R4: Each completion is 2 write beats at `CQ_BASE + slot*16 + b*8`. Beat 0 holds the command identifier (`cmd_data[31:16]`, bytes 2 and 3 of the command) in bits [15:0] and the submission head after consumption in bits [31:16], with its upper 32 bits zero. Beat 1 holds the phase in bit 0 and `sts_code` in bits [15:1], with its upper bits zero.
- R5: The completion phase is 1 after reset and inverts every time the completion tail wraps from `DEPTH-1` to 0.
- R6: `irq` is high exactly while the completion tail differs from the completion head. It rises only in the cycle after the final write beat of a completion is accepted.
- R7: A doorbell write with `db_sel`=1 and a value below `DEPTH` sets the completion head, which frees the slots before it.
- R8: A doorbell write whose value is `DEPTH` or more changes no pointer and sets `db_err`, which then stays high until reset.
- R9: No fetch starts while `DEPTH-1` completion slots are occupied. Fetching resumes once the head doorbell frees a slot.
- R10: Submission and completion slot indices wrap from `DEPTH-1` to 0, both in the addresses used and in the reported submission head.
- R11: The engine drives either a memory request or `cmd_valid`, never both. The status is accepted only after the command handshake.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| db_we | input | 1 | Doorbell write strobe |
| db_sel | input | 1 | 0: submission tail, 1: completion head |
| db_val | input | DBW | Doorbell value |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | 1 write, 0 read |
| mem_addr | output | AW | Byte address of the 64-bit beat |
| mem_wdata | output | 64 | Write data |
| mem_ack | input | 1 | Beat accepted this cycle; read data valid |
| mem_rdata | input | 64 | Read data |
| cmd_valid | output | 1 | Command offered to executor |
| cmd_ready | input | 1 | Executor takes command |
| cmd_data | output | 512 | Fetched command |
| sts_valid | input | 1 | Execution status valid |
| sts_code | input | 15 | Execution status |
| irq | output | 1 | Interrupt request |
| db_err | output | 1 | Sticky bad-doorbell flag |

## Verification
A read beat's data is captured on the clock edge at which `mem_ack` is high. A write beat is complete on that same edge. `irq` and the completion tail change on the edge that accepts the second write beat. Pointer updates and `db_err` follow the edge after a doorbell strobe. The bench drives all inputs and checks all outputs on the falling edge. Each prediction is updated at the falling edge that sets up the accepting rising edge, and is compared at the next falling edge. No result is read in the same half-cycle as the edge that produces it.

// File: rtl/hq_doorbell_engine.sv
module hq_doorbell_engine #(
  parameter int DEPTH = 8,
  parameter int AW = 32,
  parameter int DBW = 16,
  parameter logic [AW-1:0] SQ_BASE = 32'h0000_1000,
  parameter logic [AW-1:0] CQ_BASE = 32'h0000_8000
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           db_we,
  input  logic           db_sel,
  input  logic [DBW-1:0] db_val,
  output logic           mem_req,
  output logic           mem_we,
  output logic [AW-1:0]  mem_addr,
  output logic [63:0]    mem_wdata,
  input  logic           mem_ack,
  input  logic [63:0]    mem_rdata,
  output logic           cmd_valid,
  input  logic           cmd_ready,
  output logic [511:0]   cmd_data,
  input  logic           sts_valid,
  input  logic [14:0]    sts_code,
  output logic           irq,
  output logic           db_err
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int SQ_BEATS = 8;
  localparam int CQ_BEATS = 2;

  typedef enum logic [2:0] {S_IDLE, S_FETCH, S_ISSUE, S_WAIT, S_POST} st_t;

  st_t            st;
  logic [PW-1:0]  sqh, sqt, cqh, cqt;
  logic           phase;
  logic [2:0]     beat;
  logic [14:0]    sts;
  logic [511:0]   cbuf;

  function automatic logic [PW-1:0] nxt(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  wire db_ok   = db_val < DBW'(DEPTH);
  wire cq_full = nxt(cqt) == cqh;
  wire last_rd = beat == 3'(SQ_BEATS - 1);
  wire last_wr = beat == 3'(CQ_BEATS - 1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE; sqh <= '0; sqt <= '0; cqh <= '0; cqt <= '0;
      phase <= 1'b1; beat <= '0; sts <= '0; cbuf <= '0; db_err <= 1'b0;
    end else begin
      if (db_we && db_ok && !db_sel) sqt <= db_val[PW-1:0];
      if (db_we && db_ok && db_sel)  cqh <= db_val[PW-1:0];
      if (db_we && !db_ok)           db_err <= 1'b1;
      case (st)
        S_IDLE: if (sqh != sqt && !cq_full) begin
          st <= S_FETCH; beat <= '0;
        end
        S_FETCH: if (mem_ack) begin
          cbuf[{beat, 6'b0} +: 64] <= mem_rdata;
          beat <= beat + 1'b1;
          if (last_rd) begin sqh <= nxt(sqh); st <= S_ISSUE; end
        end
        S_ISSUE: if (cmd_ready) st <= S_WAIT;
        S_WAIT: if (sts_valid) begin
          sts <= sts_code; beat <= '0; st <= S_POST;
        end
        S_POST: if (mem_ack) begin
          beat <= beat + 1'b1;
          if (last_wr) begin
            cqt <= nxt(cqt);
            if (nxt(cqt) == '0) phase <= ~phase;
            st <= S_IDLE;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assign mem_req   = (st == S_FETCH) || (st == S_POST);
  assign mem_we    = st == S_POST;
  assign mem_addr  = mem_we ? CQ_BASE + (AW'(cqt) << 4) + (AW'(beat[0]) << 3)
                            : SQ_BASE + (AW'(sqh) << 6) + (AW'(beat) << 3);
  assign mem_wdata = beat[0] ? {48'b0, sts, phase} : {32'b0, 16'(sqh), cbuf[31:16]};
  assign cmd_valid = st == S_ISSUE;
  assign cmd_data  = cbuf;
  assign irq       = cqt != cqh;

  a_r2_fetch_in_ring: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_we) |-> (mem_addr >= SQ_BASE && mem_addr < SQ_BASE + AW'(DEPTH * 64)));
  a_r3_cmd_held: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !cmd_ready) |=> (cmd_valid && $stable(cmd_data)));
  a_r6_irq_after_post: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(irq) && !$past(db_we)) |-> $past(mem_req && mem_we && mem_ack));
  a_r8_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    db_err |=> db_err);
  a_r9_no_fetch_full: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_req && !mem_we) |-> !$past(cq_full));
  a_r11_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(cmd_valid && mem_req));
endmodule

// File: tb/tb_hq_doorbell_engine.sv
module tb_hq_doorbell_engine;
  localparam int D = 8;
  localparam logic [31:0] SQB = 32'h0000_1000;
  localparam logic [31:0] CQB = 32'h0000_8000;

  logic clk = 0, rst_n = 0;
  logic db_we = 0, db_sel = 0;
  logic [15:0] db_val = 0;
  logic mem_req, mem_we, mem_ack = 0, cmd_valid, cmd_ready = 0, sts_valid = 0, irq, db_err;
  logic [31:0] mem_addr;
  logic [63:0] mem_wdata, mem_rdata = 0;
  logic [511:0] cmd_data;
  logic [14:0] sts_code = 0;

  hq_doorbell_engine dut (.clk(clk), .rst_n(rst_n), .db_we(db_we), .db_sel(db_sel), .db_val(db_val),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_ack(mem_ack),
    .mem_rdata(mem_rdata), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_data(cmd_data),
    .sts_valid(sts_valid), .sts_code(sts_code), .irq(irq), .db_err(db_err));

  always #5 clk = ~clk;

  int checks = 0, errors = 0, cycles = 0;
  int m_sqh = 0, m_sqt = 0, m_cqh = 0, m_cqt = 0, m_phase = 1, m_err = 0;
  int rb = 0, wb = 0, posted = 0, fetches = 0, ex_st = 0, ex_cnt = 0;
  logic [15:0] sq_cid [D];
  logic [15:0] cur_cid = 0, next_cid = 16'h0100;

  function automatic logic [63:0] cmd_word(input logic [15:0] cid, input int b);
    return {16'(b) * 16'h1111, cid ^ 16'(b), cid, 16'(b)};
  endfunction

  task automatic chk(input bit ok, input string req, input logic [511:0] act, input logic [511:0] exp);
    checks++;
    if (!ok) begin errors++; $display("FAIL %s actual=%0h expected=%0h", req, act, exp); end
  endtask

  always @(negedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      errors++; $display("FAIL watchdog actual=%0d expected<100000", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
    if (rst_n) begin
      chk(irq == (m_cqt != m_cqh), "R6 irq level", irq, m_cqt != m_cqh);
      chk(db_err == m_err[0], "R8 db_err", db_err, m_err);
      case (ex_st)
        0: if (cmd_valid) begin
             ex_cnt++;
             if (ex_cnt == 2) begin
               logic [511:0] e;
               for (int b = 0; b < 8; b++) e[64*b +: 64] = cmd_word(cur_cid, b);
               chk(cmd_data == e, "R3 cmd_data", cmd_data, e);
               cmd_ready = 1; ex_st = 1; ex_cnt = 0;
             end
           end
        1: begin cmd_ready = 0; ex_st = 2; end
        2: begin ex_cnt++; if (ex_cnt == 3) begin
             sts_valid = 1; sts_code = cur_cid[14:0] ^ 15'h1234; ex_st = 3; ex_cnt = 0; end end
        default: begin sts_valid = 0; ex_st = 0; end
      endcase
      if (mem_ack) mem_ack = 0;
      else if (mem_req) begin
        chk(!cmd_valid, "R11 exclusive", cmd_valid, 0);
        if (!mem_we) begin
          if (rb == 0) begin
            chk(m_sqh != m_sqt, "R2 fetch only when pending", m_sqh, m_sqt);
            chk(((m_cqt - m_cqh + D) % D) < D - 1, "R9 no fetch when full", m_cqt, m_cqh);
            cur_cid = sq_cid[m_sqh];
            fetches++;
          end
          chk(mem_addr == SQB + 32'(m_sqh * 64 + rb * 8), "R2 R10 fetch addr", mem_addr, SQB + 32'(m_sqh * 64 + rb * 8));
          mem_rdata = cmd_word(sq_cid[(mem_addr - SQB) >> 6], int'(mem_addr[5:3]));
          rb++;
          if (rb == 8) begin rb = 0; m_sqh = (m_sqh + 1) % D; end
        end else begin
          logic [63:0] ew;
          ew = (wb == 0) ? {32'b0, 16'(m_sqh), cur_cid} : {48'b0, cur_cid[14:0] ^ 15'h1234, m_phase[0]};
          chk(mem_addr == CQB + 32'(m_cqt * 16 + wb * 8), "R4 R10 post addr", mem_addr, CQB + 32'(m_cqt * 16 + wb * 8));
          chk(mem_wdata == ew, "R4 R5 post data", mem_wdata, ew);
          wb++;
          if (wb == 2) begin
            wb = 0; posted++; m_cqt = (m_cqt + 1) % D;
            if (m_cqt == 0) m_phase = 1 - m_phase;
          end
        end
        mem_ack = 1;
      end
    end
  end

  task automatic ring(input bit sel, input int v);
    @(negedge clk); #1;
    db_we = 1; db_sel = sel; db_val = 16'(v);
    if (v >= D) m_err = 1;
    else if (sel) m_cqh = v;
    else m_sqt = v;
    @(negedge clk); #1; db_we = 0;
  endtask

  task automatic load(input int from, input int to);
    for (int s = from; s != to; s = (s + 1) % D) begin sq_cid[s] = next_cid; next_cid += 16'h0107; end
  endtask

  task automatic wait_posted(input int n);
    for (int i = 0; i < 3000 && posted < n; i++) @(negedge clk);
    chk(posted == n, "R2 R4 completions", posted, n);
  endtask

  initial begin
    for (int s = 0; s < D; s++) sq_cid[s] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk); #1;
    chk(!irq && !mem_req && !cmd_valid && !db_err, "R1 reset outputs", {irq, mem_req, cmd_valid, db_err}, 0);
    repeat (10) @(negedge clk); #1;
    chk(fetches == 0, "R1 idle without doorbell", fetches, 0);
    load(0, 3); ring(0, 3);
    wait_posted(3);
    @(negedge clk); #1;
    chk(irq == 1, "R6 irq pending", irq, 1);
    ring(1, 3);
    @(negedge clk); #1;
    chk(irq == 0, "R7 head frees", irq, 0);
    ring(0, 9); ring(1, 12);
    repeat (20) @(negedge clk); #1;
    chk(db_err == 1 && posted == 3 && fetches == 3, "R8 bad doorbell ignored", {db_err, 8'(posted)}, {1'b1, 8'd3});
    chk(irq == 0, "R8 head unchanged", irq, 0);
    load(3, 1); ring(0, 1);
    wait_posted(9);
    ring(1, 1);
    load(1, 6); ring(0, 6);
    wait_posted(14);
    load(6, 3); ring(0, 3);
    repeat (400) @(negedge clk); #1;
    chk(posted == 16, "R9 stall at full ring", posted, 16);
    chk(irq == 1, "R9 irq while full", irq, 1);
    ring(1, m_cqt);
    wait_posted(19);
    ring(1, m_cqt);
    repeat (5) @(negedge clk); #1;
    chk(!irq && !mem_req && db_err, "R5 R10 final idle", {irq, mem_req, db_err}, 1);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule